// File: doc/BRIEF.md
# Precise Trap Controller for a Five-Stage In-Order Pipeline

This block is the control slice of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) that turns exception conditions into a precise trap. For each instruction that leaves fetch it follows a valid bit, the program counter, whether the instruction writes a register or performs a store, and any pending exception with its cause code. Two sources raise exceptions. A trapping signed add that overflows in execute is one. A translation-miss flag reported while the instruction sits in the memory stage is the other. An exception is only recorded while the instruction moves down the pipe. It is acted on when the instruction reaches writeback still valid.

Branches and jumps are resolved in decode elsewhere. Exceptions are committed here, at writeback. In the cycle a valid, excepting instruction is in writeback, the block does four things. It blocks that instruction's register write. It gates off any store from the younger instruction in the memory stage. It marks every younger in-flight instruction invalid, effective at the next clock edge. It forces the fetch program counter to a fixed handler address for the following cycle. A cause register and a faulting-address register are loaded at that same edge and hold their values until the next trap.

Top module: `precise_trap_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, all four stage valid bits are 0, `trap_take` is 0, `fetch_pc` equals RESET_PC (default 0), and `trap_cause` and `trap_epc` are 0.
- R2: An instruction fetched in cycle t (with `fetch_valid`=1 at `fetch_pc`) takes its register/store flags from the decode inputs in cycle t+1, its add inputs in t+2 and its miss flag in t+3, and is in writeback in cycle t+4. There `wb_reg_we` is 1 if it writes a register, it is valid, and it carries no exception.
- R3: A valid instruction in execute with `ex_trap_add`=1 whose two's-complement signed sum of `ex_op_a` and `ex_op_b` overflows raises cause code 0, and it traps when it reaches writeback. A sum without overflow, or an overflowing add with `ex_trap_add`=0, raises nothing.
- R4: `mem_tlb_miss`=1 while a valid instruction is in the memory stage raises cause code 1 for it, unless that instruction already carries an overflow exception, in which case cause 0 is kept.
- R5: In a cycle where `trap_take` is 1, all four stage valid bits (`stage_valid` bit 0 decode, 1 execute, 2 memory, 3 writeback) are 0 in the next cycle.
- R6: `fetch_pc` advances by PC_STEP (default 4) every cycle. In the cycle after `trap_take`=1 it equals HANDLER_PC (default 0x80), and it advances from there.
- R7: In the cycle after a trap, `trap_epc` holds the program counter of the trapping instruction and `trap_cause` holds its cause code. Both hold their values in every cycle without a trap.
- R8: `mem_store_en` is 1 only for a valid store in the memory stage that carries no exception (including a miss in that same cycle), and only when no trap is being taken in that cycle.
- R9: Only the oldest excepting instruction traps. An instruction squashed by a trap never raises `trap_take`, even if it had overflowed, and `trap_take` is never 1 in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | An instruction is fetched at `fetch_pc` this cycle |
| id_writes_reg | input | 1 | Instruction in decode writes a register |
| id_is_store | input | 1 | Instruction in decode is a store |
| ex_trap_add | input | 1 | Instruction in execute is a trapping signed add |
| ex_op_a | input | 32 | First add operand in execute |
| ex_op_b | input | 32 | Second add operand in execute |
| mem_tlb_miss | input | 1 | Translation miss for the instruction in the memory stage |
| fetch_pc | output | 32 | Program counter of the current fetch |
| stage_valid | output | 4 | Valid bits: 0 decode, 1 execute, 2 memory, 3 writeback |
| mem_store_en | output | 1 | Store in the memory stage may write memory |
| wb_reg_we | output | 1 | Writeback instruction may write the register file |
| trap_take | output | 1 | A trap is committed this cycle |
| trap_cause | output | 4 | Cause of the last trap (0 overflow, 1 miss) |
| trap_epc | output | 32 | Program counter of the last trapping instruction |

## Verification
The combinational results are due in the same cycle as the state that produces them. `trap_take` and `wb_reg_we` come four cycles after the fetch, `mem_store_en` three cycles after. The bench drives each cycle's inputs just after the falling edge and samples every output one nanosecond before the next rising edge, so one table row corresponds to one cycle. The effects of a trap are registered and land one cycle later: the cleared valid bits, the handler address on `fetch_pc`, and the new cause and faulting address. The table therefore expects them in the row after the row with `trap_take`=1. Directed checks after the table confirm the redirected count, the overflow-over-miss cause priority, and the reset values.

// File: rtl/xcpt_pkg.sv
package xcpt_pkg;

    localparam int XLEN    = 32;
    localparam int CAUSE_W = 4;
    localparam int NSTAGE  = 4;   // tracked stages: decode, execute, memory, writeback

    typedef logic [CAUSE_W-1:0] cause_t;

    localparam cause_t CAUSE_OVF  = cause_t'(0);
    localparam cause_t CAUSE_XMISS = cause_t'(1);

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] pc;
        logic            wr;
        logic            st;
        logic            exc;
        cause_t          cause;
    } slot_t;

    function automatic logic add_overflows(input logic [XLEN-1:0] a,
                                           input logic [XLEN-1:0] b);
        logic [XLEN-1:0] s;
        s = a + b;
        return (a[XLEN-1] == b[XLEN-1]) && (s[XLEN-1] != a[XLEN-1]);
    endfunction

endpackage

// File: rtl/xcpt_stage_reg.sv
module xcpt_stage_reg
    import xcpt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  slot_t d,
    output slot_t q
);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/xcpt_detect.sv
module xcpt_detect
    import xcpt_pkg::*;
(
    input  slot_t           cur_id,
    input  slot_t           cur_ex,
    input  slot_t           cur_mem,
    input  logic            id_writes_reg,
    input  logic            id_is_store,
    input  logic            ex_trap_add,
    input  logic [XLEN-1:0] ex_op_a,
    input  logic [XLEN-1:0] ex_op_b,
    input  logic            mem_tlb_miss,
    input  logic            trap_now,
    output slot_t           nxt_ex,
    output slot_t           nxt_mem,
    output slot_t           nxt_wb,
    output logic            mem_store_en
);

    logic ovf_hit;
    logic miss_hit;

    // decode: attach the instruction's register/store attributes
    always_comb begin
        nxt_ex    = cur_id;
        nxt_ex.wr = cur_id.valid & id_writes_reg;
        nxt_ex.st = cur_id.valid & id_is_store;
    end

    // execute: trapping signed add overflow
    assign ovf_hit = cur_ex.valid && ex_trap_add && add_overflows(ex_op_a, ex_op_b);

    always_comb begin
        nxt_mem = cur_ex;
        if (!cur_ex.exc && ovf_hit) begin
            nxt_mem.exc   = 1'b1;
            nxt_mem.cause = CAUSE_OVF;
        end
    end

    // memory: translation miss, an earlier exception keeps its cause
    assign miss_hit = cur_mem.valid && mem_tlb_miss;

    always_comb begin
        nxt_wb = cur_mem;
        if (!cur_mem.exc && miss_hit) begin
            nxt_wb.exc   = 1'b1;
            nxt_wb.cause = CAUSE_XMISS;
        end
    end

    assign mem_store_en = cur_mem.valid && cur_mem.st && !nxt_wb.exc && !trap_now;

endmodule

// File: rtl/xcpt_trap_ctrl.sv
module xcpt_trap_ctrl
    import xcpt_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC   = '0,
    parameter logic [XLEN-1:0] HANDLER_PC = 32'h0000_0080,
    parameter logic [XLEN-1:0] PC_STEP    = 32'd4
) (
    input  logic            clk,
    input  logic            rst,
    input  slot_t           cur_wb,
    output logic            trap_now,
    output logic            wb_reg_we,
    output logic [XLEN-1:0] fetch_pc,
    output cause_t          trap_cause,
    output logic [XLEN-1:0] trap_epc
);

    assign trap_now  = cur_wb.valid && cur_wb.exc;
    assign wb_reg_we = cur_wb.valid && cur_wb.wr && !cur_wb.exc;

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_pc <= RESET_PC;
        end else if (trap_now) begin
            fetch_pc <= HANDLER_PC;
        end else begin
            fetch_pc <= fetch_pc + PC_STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_cause <= '0;
            trap_epc   <= '0;
        end else if (trap_now) begin
            trap_cause <= cur_wb.cause;
            trap_epc   <= cur_wb.pc;
        end
    end

    p_redirect_r6: assert property (@(posedge clk) disable iff (rst)
        trap_now |=> fetch_pc == HANDLER_PC);

    p_epc_r7: assert property (@(posedge clk) disable iff (rst)
        trap_now |=> trap_epc == $past(cur_wb.pc));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !trap_now |=> $stable(trap_cause) && $stable(trap_epc));

    p_single_r9: assert property (@(posedge clk) disable iff (rst)
        trap_now |=> !trap_now);

endmodule

// File: rtl/precise_trap_ctrl.sv
module precise_trap_ctrl
    import xcpt_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC   = '0,
    parameter logic [XLEN-1:0] HANDLER_PC = 32'h0000_0080,
    parameter logic [XLEN-1:0] PC_STEP    = 32'd4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fetch_valid,
    input  logic               id_writes_reg,
    input  logic               id_is_store,
    input  logic               ex_trap_add,
    input  logic [XLEN-1:0]    ex_op_a,
    input  logic [XLEN-1:0]    ex_op_b,
    input  logic               mem_tlb_miss,
    output logic [XLEN-1:0]    fetch_pc,
    output logic [NSTAGE-1:0]  stage_valid,
    output logic               mem_store_en,
    output logic               wb_reg_we,
    output logic               trap_take,
    output logic [CAUSE_W-1:0] trap_cause,
    output logic [XLEN-1:0]    trap_epc
);

    localparam int S_ID  = 0;
    localparam int S_EX  = 1;
    localparam int S_MEM = 2;
    localparam int S_WB  = 3;

    slot_t nxt [NSTAGE];
    slot_t cur [NSTAGE];

    // slot entering decode comes straight from fetch
    always_comb begin
        nxt[S_ID]       = '0;
        nxt[S_ID].valid = fetch_valid;
        nxt[S_ID].pc    = fetch_pc;
    end

    genvar k;
    generate
        for (k = 0; k < NSTAGE; k++) begin : g_stage
            xcpt_stage_reg u_reg (
                .clk   (clk),
                .rst   (rst),
                .flush (trap_take),
                .d     (nxt[k]),
                .q     (cur[k])
            );
            assign stage_valid[k] = cur[k].valid;
        end
    endgenerate

    xcpt_detect u_detect (
        .cur_id        (cur[S_ID]),
        .cur_ex        (cur[S_EX]),
        .cur_mem       (cur[S_MEM]),
        .id_writes_reg (id_writes_reg),
        .id_is_store   (id_is_store),
        .ex_trap_add   (ex_trap_add),
        .ex_op_a       (ex_op_a),
        .ex_op_b       (ex_op_b),
        .mem_tlb_miss  (mem_tlb_miss),
        .trap_now      (trap_take),
        .nxt_ex        (nxt[S_EX]),
        .nxt_mem       (nxt[S_MEM]),
        .nxt_wb        (nxt[S_WB]),
        .mem_store_en  (mem_store_en)
    );

    xcpt_trap_ctrl #(
        .RESET_PC   (RESET_PC),
        .HANDLER_PC (HANDLER_PC),
        .PC_STEP    (PC_STEP)
    ) u_trap (
        .clk        (clk),
        .rst        (rst),
        .cur_wb     (cur[S_WB]),
        .trap_now   (trap_take),
        .wb_reg_we  (wb_reg_we),
        .fetch_pc   (fetch_pc),
        .trap_cause (trap_cause),
        .trap_epc   (trap_epc)
    );

    p_flush_r5: assert property (@(posedge clk) disable iff (rst)
        trap_take |=> stage_valid == '0);

    p_ovf_rec_r3: assert property (@(posedge clk) disable iff (rst)
        (cur[S_EX].valid && !cur[S_EX].exc && ex_trap_add
         && add_overflows(ex_op_a, ex_op_b) && !trap_take)
        |=> cur[S_MEM].exc && cur[S_MEM].cause == CAUSE_OVF);

    p_miss_rec_r4: assert property (@(posedge clk) disable iff (rst)
        (cur[S_MEM].valid && !cur[S_MEM].exc && mem_tlb_miss && !trap_take)
        |=> cur[S_WB].exc && cur[S_WB].cause == CAUSE_XMISS);

endmodule

// File: tb/precise_trap_ctrl_tb_top.sv
module precise_trap_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_valid = 1'b0;
    logic        id_writes_reg = 1'b0;
    logic        id_is_store = 1'b0;
    logic        ex_trap_add = 1'b0;
    logic [31:0] ex_op_a = '0;
    logic [31:0] ex_op_b = '0;
    logic        mem_tlb_miss = 1'b0;
    logic [31:0] fetch_pc;
    logic [3:0]  stage_valid;
    logic        mem_store_en;
    logic        wb_reg_we;
    logic        trap_take;
    logic [3:0]  trap_cause;
    logic [31:0] trap_epc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    precise_trap_ctrl dut_i (
        .clk           (clk),
        .rst           (rst),
        .fetch_valid   (fetch_valid),
        .id_writes_reg (id_writes_reg),
        .id_is_store   (id_is_store),
        .ex_trap_add   (ex_trap_add),
        .ex_op_a       (ex_op_a),
        .ex_op_b       (ex_op_b),
        .mem_tlb_miss  (mem_tlb_miss),
        .fetch_pc      (fetch_pc),
        .stage_valid   (stage_valid),
        .mem_store_en  (mem_store_en),
        .wb_reg_we     (wb_reg_we),
        .trap_take     (trap_take),
        .trap_cause    (trap_cause),
        .trap_epc      (trap_epc)
    );

    typedef struct packed {
        logic        fv;
        logic        idwr;
        logic        idst;
        logic        exta;
        logic [31:0] a;
        logic [31:0] b;
        logic        tlb;
        logic        e_trap;
        logic        e_we;
        logic        e_st;
        logic [31:0] e_pc;
        logic [3:0]  e_cause;
        logic [31:0] e_epc;
        logic [3:0]  e_val;
    } vec_t;

    localparam int NVEC = 14;
    // one row per cycle; outputs sampled 1 ns before the rising edge
    localparam vec_t VEC [NVEC] = '{
        '{1'b1,1'b0,1'b0,1'b0,32'h0,32'h0,1'b0, 1'b0,1'b0,1'b0,32'h00,4'd0,32'h00,4'b0000},
        '{1'b1,1'b1,1'b0,1'b0,32'h0,32'h0,1'b0, 1'b0,1'b0,1'b0,32'h04,4'd0,32'h00,4'b0001},
        '{1'b1,1'b0,1'b1,1'b0,32'h0,32'h0,1'b0, 1'b0,1'b0,1'b0,32'h08,4'd0,32'h00,4'b0011},
        '{1'b1,1'b1,1'b0,1'b0,32'h0,32'h0,1'b0, 1'b0,1'b0,1'b0,32'h0c,4'd0,32'h00,4'b0111},
        '{1'b1,1'b1,1'b0,1'b1,32'h1,32'h2,1'b0, 1'b0,1'b1,1'b1,32'h10,4'd0,32'h00,4'b1111},
        '{1'b1,1'b0,1'b1,1'b0,32'h7fffffff,32'h1,1'b0, 1'b0,1'b0,1'b0,32'h14,4'd0,32'h00,4'b1111},
        '{1'b1,1'b0,1'b1,1'b0,32'h0,32'h0,1'b0, 1'b0,1'b1,1'b0,32'h18,4'd0,32'h00,4'b1111},
        '{1'b1,1'b1,1'b0,1'b0,32'h0,32'h0,1'b1, 1'b0,1'b1,1'b0,32'h1c,4'd0,32'h00,4'b1111},
        '{1'b1,1'b1,1'b0,1'b1,32'h7fffffff,32'h1,1'b0, 1'b1,1'b0,1'b0,32'h20,4'd0,32'h00,4'b1111},
        '{1'b1,1'b0,1'b0,1'b0,32'h0,32'h0,1'b0, 1'b0,1'b0,1'b0,32'h80,4'd1,32'h10,4'b0000},
        '{1'b1,1'b1,1'b0,1'b0,32'h0,32'h0,1'b0, 1'b0,1'b0,1'b0,32'h84,4'd1,32'h10,4'b0001},
        '{1'b1,1'b1,1'b0,1'b1,32'h80000000,32'hffffffff,1'b0, 1'b0,1'b0,1'b0,32'h88,4'd1,32'h10,4'b0011},
        '{1'b1,1'b0,1'b1,1'b0,32'h0,32'h0,1'b1, 1'b0,1'b0,1'b0,32'h8c,4'd1,32'h10,4'b0111},
        '{1'b1,1'b1,1'b0,1'b0,32'h0,32'h0,1'b0, 1'b1,1'b0,1'b0,32'h90,4'd1,32'h10,4'b1111}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive_idle();
        fetch_valid   = 1'b0;
        id_writes_reg = 1'b0;
        id_is_store   = 1'b0;
        ex_trap_add   = 1'b0;
        ex_op_a       = '0;
        ex_op_b       = '0;
        mem_tlb_miss  = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        drive_idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        #4;
        // R1: values while reset is held
        chk("R1 valid in reset", {28'd0, stage_valid}, 32'd0);
        chk("R1 pc in reset", fetch_pc, 32'h0);
        chk("R1 trap in reset", {31'd0, trap_take}, 32'd0);

        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NVEC; i++) begin
            if (i != 0) @(negedge clk);
            fetch_valid   = VEC[i].fv;
            id_writes_reg = VEC[i].idwr;
            id_is_store   = VEC[i].idst;
            ex_trap_add   = VEC[i].exta;
            ex_op_a       = VEC[i].a;
            ex_op_b       = VEC[i].b;
            mem_tlb_miss  = VEC[i].tlb;
            #4;
            chk("R3/R4/R9 trap_take", {31'd0, trap_take}, {31'd0, VEC[i].e_trap});
            chk("R2 wb_reg_we", {31'd0, wb_reg_we}, {31'd0, VEC[i].e_we});
            chk("R8 mem_store_en", {31'd0, mem_store_en}, {31'd0, VEC[i].e_st});
            chk("R6 fetch_pc", fetch_pc, VEC[i].e_pc);
            chk("R7 trap_cause", {28'd0, trap_cause}, {28'd0, VEC[i].e_cause});
            chk("R7 trap_epc", trap_epc, VEC[i].e_epc);
            chk("R5 stage_valid", {28'd0, stage_valid}, {28'd0, VEC[i].e_val});
        end

        // cycle after the overflow trap of the handler's first instruction
        @(negedge clk);
        drive_idle();
        #4;
        chk("R3 cause overflow kept over miss (R4)", {28'd0, trap_cause}, 32'd0);
        chk("R7 epc of handler instruction", trap_epc, 32'h80);
        chk("R6 pc back at handler", fetch_pc, 32'h80);
        chk("R5 valid cleared", {28'd0, stage_valid}, 32'd0);
        chk("R9 no back-to-back trap", {31'd0, trap_take}, 32'd0);

        @(negedge clk);
        #4;
        chk("R6 pc advances from handler", fetch_pc, 32'h84);
        chk("R7 cause held", {28'd0, trap_cause}, 32'd0);

        // R1: reset clears captured trap state
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #4;
        chk("R1 cause after reset", {28'd0, trap_cause}, 32'd0);
        chk("R1 epc after reset", trap_epc, 32'd0);
        chk("R1 pc after reset", fetch_pc, 32'h0);
        chk("R1 valid after reset", {28'd0, stage_valid}, 32'd0);
        chk("R1 trap after reset", {31'd0, trap_take}, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule